// File: doc/BRIEF.md
# Three-Port Shared Word Memory with Bus Slave Ports

This block lets three independent bus masters share one single-port synchronous RAM. Each master has its own Wishbone classic slave port. All three ports reach the same storage, so a word written through one port can be read back through any other. The ports share one clock and one synchronous active-low reset.

A port raises a request by holding its cycle and strobe lines high. A round-robin arbiter picks one pending port per clock and performs exactly one RAM read or write for it at that clock edge. In the following cycle it raises that port's acknowledge for one clock, with read data valid on the port's data output. The port that has just been acknowledged is masked for that cycle, so a request that is still held while its acknowledge is high is never served twice. A master that keeps its strobe high past the acknowledge starts a new request.

Top module: `wbram_tri_port`

## Requirements
- R1: A port's request is valid only while both its cyc and stb inputs are high; with stb high and cyc low, no acknowledge is given and no RAM write takes place.
- R2: Each access is acknowledged by a single one-clock pulse on the granted port's ack_o bit, and at most one bit of ack_o is high in any cycle.
- R3: For a read (we low), the addressed word is on that port's 32-bit slice of dat_o (port p at bits p*32+31..p*32) in the cycle its ack is high.
- R4: A write (we high) stores the port's data word at its address, and a later read from any port returns that word.
- R5: Arbitration is round-robin. After reset the lowest-numbered pending port (port 0) has the highest priority. After port k is served, priority starts at port k+1 and wraps after port 2, so ports that request together out of reset are served in the order 0, 1, 2, each one clock after the one before.
- R6: A request that is held until acknowledged gets its ack within NPORT+1 cycles, whatever the other ports do.
- R7: When two ports access the same address in a conflict, the access granted later sees the write granted earlier.
- R8: While rst_n is low, every ack_o bit is low and no RAM write takes place. After reset the arbiter pointer is at port 0.
- R9: A port that keeps cyc and stb high after its ack is served again as a new request. With no other requester, it is acknowledged every second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all ports |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_i | input | 3 | Bus cycle line, one bit per port |
| stb_i | input | 3 | Strobe line, one bit per port |
| we_i | input | 3 | Write enable per port (1 = write) |
| adr_i | input | 24 | Word address, 8 bits per port, port p at bits p*8+7..p*8 |
| dat_i | input | 96 | Write data, 32 bits per port |
| dat_o | output | 96 | Read data, 32 bits per port, valid while that port's ack is high |
| ack_o | output | 3 | Acknowledge pulse, one bit per port |

## Verification
The assertions assume every master behaves as a classic bus master. Once it raises cyc and stb, it holds them, together with we, address and data, until it has sampled its ack high. Only under that assumption does the wait-bound counter in each port slot prove freedom from starvation. The bench drives each port through one transfer task that sets its lines just after a clock edge, waits for the ack at falling edges and drops the lines after the next rising edge. Its only departures are deliberate ones: a strobe without cyc, a request held through reset, and a strobe held across consecutive requests.

// File: rtl/wbram_pkg.sv
// Package: shared sizing constants for the three-port shared memory.
// Assumes: every module takes its defaults from here so widths line up.
package wbram_pkg;
    localparam int unsigned DEF_NPORT = 3;
    localparam int unsigned DEF_AW    = 8;
    localparam int unsigned DEF_DW    = 32;
endpackage

// File: rtl/wbram_spram.sv
// Module: single-port synchronous RAM, read or write on one enabled edge.
// Assumes: the caller raises en for at most one access per clock; the read
// data register keeps its value on write and idle cycles.
module wbram_spram #(
    parameter int unsigned AW = wbram_pkg::DEF_AW,
    parameter int unsigned DW = wbram_pkg::DEF_DW
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] adr,
    input  logic [DW-1:0] wdat,
    output logic [DW-1:0] rdat
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Purpose: perform the single granted access of this clock.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[adr] <= wdat;
            else    rdat     <= mem[adr];
        end
    end
endmodule

// File: rtl/wbram_rr_arb.sv
// Module: round-robin arbiter picking one eligible port per clock.
// Assumes: req is already masked for ports being acknowledged; the pointer
// moves to the port after the one granted and resets to port 0.
module wbram_rr_arb #(
    parameter int unsigned NPORT = wbram_pkg::DEF_NPORT
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPORT-1:0]         req,
    output logic                     gvalid,
    output logic [$clog2(NPORT)-1:0] gidx
);
    localparam int unsigned IW = $clog2(NPORT);

    logic [IW-1:0] ptr;

    // Purpose: search the requests starting at the pointer, wrapping around.
    always_comb begin
        gvalid = 1'b0;
        gidx   = '0;
        for (int i = 0; i < int'(NPORT); i++) begin
            int idx;
            idx = int'(ptr) + i;
            if (idx >= int'(NPORT)) idx = idx - int'(NPORT);
            if (!gvalid && req[idx] && rst_n) begin
                gvalid = 1'b1;
                gidx   = IW'(idx);
            end
        end
    end

    // Purpose: rotate priority past the port just served.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (gvalid)
            ptr <= (int'(gidx) == int'(NPORT) - 1) ? '0 : gidx + 1'b1;
    end

    // R5: a port served this clock is not first in line on the next clock
    p_ptr_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gvalid |=> ptr != $past(gidx));
endmodule

// File: rtl/wbram_slot.sv
// Module: per-port request qualifier and acknowledge register.
// Assumes: a master holds its request lines until it samples ack high; the
// wait counter below checks starvation only under that assumption.
module wbram_slot #(
    parameter int unsigned NPORT = wbram_pkg::DEF_NPORT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc,
    input  logic stb,
    input  logic grant,
    output logic elig,
    output logic ack
);
    localparam int unsigned LIMIT = NPORT + 1;
    localparam int unsigned CW    = $clog2(LIMIT + 2) + 1;

    logic          req;
    logic [CW-1:0] wait_cnt;

    assign req  = cyc & stb;
    assign elig = req & ~ack;

    // Purpose: pulse ack in the cycle after the RAM access for this port.
    always_ff @(posedge clk) begin
        if (!rst_n) ack <= 1'b0;
        else        ack <= grant;
    end

    // Purpose: count cycles a held request has waited without an ack.
    always_ff @(posedge clk) begin
        if (!rst_n || !req || ack)
            wait_cnt <= '0;
        else if (wait_cnt != {CW{1'b1}})
            wait_cnt <= wait_cnt + 1'b1;
    end

    // R1: an ack always answers a request that was valid on the grant clock
    p_ack_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(req));
    // R2: an acknowledge lasts exactly one clock
    p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    // R6: a held request is answered within the bound
    p_no_starve_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt <= CW'(LIMIT));
    // R8: reset clears the acknowledge
    p_reset_ack_r8: assert property (@(posedge clk)
        !rst_n |=> !ack);
endmodule

// File: rtl/wbram_tri_port.sv
// Module: three bus slave ports time-sharing one single-port RAM.
// Assumes: classic single-word transfers; masters hold their lines until
// ack. One access per clock, ack and read data one clock after the grant.
module wbram_tri_port #(
    parameter int unsigned NPORT = wbram_pkg::DEF_NPORT,
    parameter int unsigned AW    = wbram_pkg::DEF_AW,
    parameter int unsigned DW    = wbram_pkg::DEF_DW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NPORT-1:0]    cyc_i,
    input  logic [NPORT-1:0]    stb_i,
    input  logic [NPORT-1:0]    we_i,
    input  logic [NPORT*AW-1:0] adr_i,
    input  logic [NPORT*DW-1:0] dat_i,
    output logic [NPORT*DW-1:0] dat_o,
    output logic [NPORT-1:0]    ack_o
);
    localparam int unsigned IW = $clog2(NPORT);

    logic [NPORT-1:0] elig;
    logic [NPORT-1:0] grant;
    logic             gvalid;
    logic [IW-1:0]    gidx;
    logic             ram_we;
    logic [AW-1:0]    ram_adr;
    logic [DW-1:0]    ram_wdat;
    logic [DW-1:0]    ram_rdat;

    for (genvar p = 0; p < int'(NPORT); p++) begin : g_slot
        assign grant[p] = gvalid && (int'(gidx) == p);

        wbram_slot #(.NPORT(NPORT)) i_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .cyc   (cyc_i[p]),
            .stb   (stb_i[p]),
            .grant (grant[p]),
            .elig  (elig[p]),
            .ack   (ack_o[p])
        );

        assign dat_o[p*DW +: DW] = ram_rdat;
    end

    wbram_rr_arb #(.NPORT(NPORT)) i_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (elig),
        .gvalid (gvalid),
        .gidx   (gidx)
    );

    // Purpose: steer the granted port's command to the RAM.
    always_comb begin
        ram_we   = we_i[gidx];
        ram_adr  = adr_i[gidx*AW +: AW];
        ram_wdat = dat_i[gidx*DW +: DW];
    end

    wbram_spram #(.AW(AW), .DW(DW)) i_ram (
        .clk  (clk),
        .en   (gvalid),
        .we   (ram_we),
        .adr  (ram_adr),
        .wdat (ram_wdat),
        .rdat (ram_rdat)
    );

    // R2: never two ports acknowledged together
    p_ack_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_o));
    // R8: no RAM access is launched while reset is held
    p_reset_no_access_r8: assert property (@(posedge clk)
        !rst_n |-> !gvalid);
endmodule

// File: tb/test_wbram_tri_port.sv
module test_wbram_tri_port;
    localparam int N = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cyc_b [N];
    logic          stb_b [N];
    logic          we_b  [N];
    logic [7:0]    adr_b [N];
    logic [31:0]   dat_b [N];
    logic [N-1:0]    cyc_i, stb_i, we_i, ack_o;
    logic [N*8-1:0]  adr_i;
    logic [N*32-1:0] dat_i, dat_o;

    int checks = 0;
    int errors = 0;
    int cyc_cnt = 0;
    logic [31:0] rd [N];
    int          st [N];

    assign cyc_i = {cyc_b[2], cyc_b[1], cyc_b[0]};
    assign stb_i = {stb_b[2], stb_b[1], stb_b[0]};
    assign we_i  = {we_b[2],  we_b[1],  we_b[0]};
    assign adr_i = {adr_b[2], adr_b[1], adr_b[0]};
    assign dat_i = {dat_b[2], dat_b[1], dat_b[0]};

    wbram_tri_port i_wbram_tri_port (
        .clk(clk), .rst_n(rst_n), .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i),
        .adr_i(adr_i), .dat_i(dat_i), .dat_o(dat_o), .ack_o(ack_o));

    always #5 clk = ~clk;
    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle_all();
        for (int p = 0; p < N; p++) begin
            cyc_b[p] = 0; stb_b[p] = 0; we_b[p] = 0; adr_b[p] = 0; dat_b[p] = 0;
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1 rst_n = 0; idle_all();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
    endtask

    task automatic xfer(input int p, input bit w, input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        cyc_b[p] = 1; stb_b[p] = 1; we_b[p] = w; adr_b[p] = a; dat_b[p] = d;
        forever begin
            @(negedge clk);
            if (ack_o[p]) break;
        end
        rd[p] = dat_o[p*32 +: 32];
        st[p] = cyc_cnt;
        @(posedge clk); #1;
        cyc_b[p] = 0; stb_b[p] = 0; we_b[p] = 0;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        check(ack_o == 0, "R8 acks low in reset", ack_o, 0);
    endtask

    task automatic t_write_read();
        xfer(0, 1, 8'h10, 32'hA5A5_0001);
        xfer(1, 1, 8'h11, 32'h1234_5678);
        xfer(2, 0, 8'h10, 0);
        check(rd[2] == 32'hA5A5_0001, "R4 port2 reads port0 word", rd[2], 32'hA5A5_0001);
        xfer(0, 0, 8'h11, 0);
        check(rd[0] == 32'h1234_5678, "R3 port0 read data with ack", rd[0], 32'h1234_5678);
        xfer(1, 0, 8'h10, 0);
        check(rd[1] == 32'hA5A5_0001, "R4 port1 reads shared word", rd[1], 32'hA5A5_0001);
    endtask

    task automatic t_no_cyc();
        int acks = 0;
        xfer(0, 1, 8'h03, 32'h0000_0033);
        @(posedge clk); #1;
        stb_b[0] = 1; cyc_b[0] = 0; we_b[0] = 1; adr_b[0] = 8'h03; dat_b[0] = 32'hDEAD_BEEF;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (ack_o[0]) acks++;
        end
        @(posedge clk); #1 idle_all();
        check(acks == 0, "R1 no ack without cyc", acks, 0);
        xfer(1, 0, 8'h03, 0);
        check(rd[1] == 32'h0000_0033, "R1 strobe alone wrote nothing", rd[1], 32'h33);
    endtask

    task automatic t_reset_blocks();
        int acks = 0;
        xfer(0, 1, 8'h04, 32'h0000_0044);
        @(posedge clk); #1;
        rst_n = 0;
        cyc_b[0] = 1; stb_b[0] = 1; we_b[0] = 1; adr_b[0] = 8'h04; dat_b[0] = 32'h0BAD_0BAD;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (ack_o != 0) acks++;
        end
        @(posedge clk); #1 rst_n = 1; idle_all();
        check(acks == 0, "R8 no ack during reset", acks, 0);
        xfer(2, 0, 8'h04, 0);
        check(rd[2] == 32'h0000_0044, "R8 no write during reset", rd[2], 32'h44);
    endtask

    task automatic t_round_robin();
        int t0;
        do_reset();
        t0 = cyc_cnt;
        fork
            xfer(0, 0, 8'h10, 0);
            xfer(1, 0, 8'h11, 0);
            xfer(2, 0, 8'h04, 0);
        join
        check(st[1] == st[0] + 1, "R5 port1 one clock after port0", st[1], st[0] + 1);
        check(st[2] == st[1] + 1, "R5 port2 one clock after port1", st[2], st[1] + 1);
        check(st[2] - t0 <= 2 * N + 2, "R6 all served within bound", st[2] - t0, 2 * N + 2);
        check(rd[2] == 32'h0000_0044, "R3 concurrent read data", rd[2], 32'h44);
        // pointer now at port 0 after port2; serve port0 to move it to port1
        xfer(0, 0, 8'h10, 0);
        fork
            xfer(0, 0, 8'h10, 0);
            xfer(2, 0, 8'h11, 0);
        join
        check(st[2] < st[0], "R5 port2 before port0 after port0 served", st[2], st[0]);
    endtask

    task automatic t_same_addr();
        do_reset();
        fork
            xfer(0, 1, 8'h09, 32'hCAFE_0009);
            xfer(1, 0, 8'h09, 0);
        join
        check(st[1] == st[0] + 1, "R7 read granted after write", st[1], st[0] + 1);
        check(rd[1] == 32'hCAFE_0009, "R7 later read sees earlier write", rd[1], 32'hCAFE_0009);
    endtask

    task automatic t_held_strobe();
        int acks = 0;
        int pairs = 0;
        bit prev = 0;
        @(posedge clk); #1;
        cyc_b[0] = 1; stb_b[0] = 1; we_b[0] = 0; adr_b[0] = 8'h09;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (ack_o[0]) acks++;
            if (ack_o[0] && prev) pairs++;
            prev = ack_o[0];
        end
        @(posedge clk); #1 idle_all();
        check(acks == 5, "R9 held strobe acked every second cycle", acks, 5);
        check(pairs == 0, "R2 no back-to-back ack", pairs, 0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle_all();
        rst_n = 0;
        t_reset_state();
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
        t_write_read();
        t_no_cyc();
        t_reset_blocks();
        t_round_robin();
        t_same_addr();
        t_held_strobe();
        repeat (3) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule